// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is a bank of general-purpose I/O lines controlled through a small register bus. Software sets, for each line, the driven level, whether the line is an input or an output, whether its output blinks, and whether its input sense is inverted. The block drives a value and an output enable for every line.

On the input side, each pin passes through a two-flop synchroniser and then an optional inversion. The result is readable as the sampled-input register and also serves directly as the level interrupt source. A rising transition of that sampled value sets a sticky edge-pending bit, which software clears by writing zeros.

For each line, the level source and the edge source are each gated by their own enable mask and then combined. Lines are collected in groups of eight, and each group drives one interrupt request output.

Top module: `gpio_irq_unit`

## Requirements
- R1: Registers are selected by address bits [4:2] of the byte address: 0x00 output value, 0x04 direction, 0x08 blink enable, 0x0C input inversion, 0x10 sampled input, 0x14 edge pending, 0x18 edge enable, 0x1C level enable. A write takes effect at the next clock edge. A read strobe loads `bus_rdata` at the next edge, and `bus_rdata` holds that value until the next read.
- R2: `pad_oe` is the bitwise inverse of the direction register, so direction bit 1 means input and bit 0 means driven. For a line whose blink bit is 0, `pad_out` is the output-value bit.
- R3: A bit of the sampled-input register equals the pin after two synchronising flops, XOR the matching inversion bit.
- R4: The sampled-input register is read-only. A write to offset 0x10 changes nothing.
- R5: A 0-to-1 change of a sampled-input bit sets the matching edge-pending bit one cycle later. The bit then stays set through later falling changes until software clears it.
- R6: A write to the edge-pending register clears each bit written as 0 and keeps each bit written as 1.
- R7: If a rising change and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: Each line's request is (sampled-input AND level enable) OR (edge-pending AND edge enable). `irq_grp[g]` is the OR of the requests of lines 8g to 8g+7.
- R9: After reset, edge pending, edge enable, level enable, output value, blink enable and inversion are all zero, direction is all ones, and no `irq_grp` bit is set.
- R10: A line whose blink bit is 1 drives a shared square wave on `pad_out` instead of its output value. The wave is low after reset and toggles every BLINK_HALF clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | NUM_LINES | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | NUM_LINES | Registered read data |
| pad_in | input | NUM_LINES | Asynchronous pin levels |
| pad_out | output | NUM_LINES | Per-line driven value |
| pad_oe | output | NUM_LINES | Per-line output enable |
| irq_grp | output | NUM_LINES/8 | One interrupt request per group of eight lines |

## Verification
The bench times a rising input so that it reaches the edge-pending register in exactly the cycle of an all-zero clearing write. A design that let the clear win would drop that event without any sign.

It checks that partial clears keep the bits written as 1. A design with the clear sense inverted would wipe the wrong bits.

It checks that a falling input leaves a pending bit set, which a level-following implementation would fail. It also checks that a write to the sampled-input offset leaves the readback unchanged.

Further checks place the enabled sources in two different groups, to catch a group slice that is off by one. They also measure the blink interval between two toggles, which shows an off-by-one prescaler limit.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    RI_OUT    = 3'd0,
    RI_DIR    = 3'd1,
    RI_BLINK  = 3'd2,
    RI_INV    = 3'd3,
    RI_SAMPLE = 3'd4,
    RI_EPEND  = 3'd5,
    RI_EEN    = 3'd6,
    RI_LEN    = 3'd7
  } reg_idx_e;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          wave_q;
  logic          tick;

  assign tick = (cnt_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      cnt_q  <= tick ? '0 : cnt_q + 1'b1;
      wave_q <= wave_q ^ tick;
    end
  end

  assign wave = wave_q;

  // R10: between prescaler ticks the wave holds its level
  assert_wave_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave_q));

endmodule

// File: rtl/gpio_grp_or.sv
module gpio_grp_or #(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8
) (
  input  logic [NUM_LINES-1:0]            line_req,
  output logic [NUM_LINES/GROUP_SIZE-1:0] grp_req
);

  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_req[g] = |line_req[g*GROUP_SIZE +: GROUP_SIZE];
  end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8,
  parameter int BLINK_HALF = 4,
  parameter int ADDR_W     = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [NUM_LINES-1:0]            bus_wdata,
  input  logic                            bus_we,
  input  logic                            bus_re,
  output logic [NUM_LINES-1:0]            bus_rdata,
  input  logic [NUM_LINES-1:0]            pad_in,
  output logic [NUM_LINES-1:0]            pad_out,
  output logic [NUM_LINES-1:0]            pad_oe,
  output logic [NUM_LINES/GROUP_SIZE-1:0] irq_grp
);

  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE;
  localparam logic [NUM_LINES-1:0] ALL_ONES = '1;

  function automatic logic [NUM_LINES-1:0] rise_of(
    input logic [NUM_LINES-1:0] cur, input logic [NUM_LINES-1:0] prev);
    return cur & ~prev;
  endfunction

  function automatic logic [NUM_LINES-1:0] pend_next(
    input logic [NUM_LINES-1:0] cur, input logic [NUM_LINES-1:0] keep,
    input logic [NUM_LINES-1:0] set);
    return (cur & keep) | set;
  endfunction

  function automatic logic [NUM_LINES-1:0] drive_of(
    input logic [NUM_LINES-1:0] val, input logic [NUM_LINES-1:0] blink,
    input logic wave);
    return (val & ~blink) | (blink & {NUM_LINES{wave}});
  endfunction

  logic [NUM_LINES-1:0] out_q, dir_q, blink_q, inv_q;
  logic [NUM_LINES-1:0] epend_q, een_q, len_q, prev_q, rdata_q;

  logic [NUM_LINES-1:0] pin_sync;
  logic [NUM_LINES-1:0] sample_w;
  logic [NUM_LINES-1:0] rise_evt;
  logic [NUM_LINES-1:0] keep_mask;
  logic [NUM_LINES-1:0] line_req;
  logic                 clr_write;
  logic                 blink_wave;
  reg_idx_e             sel;

  assign sel = reg_idx_e'(bus_addr[2 +: REG_IDX_W]);

  gpio_sync2 #(.WIDTH(NUM_LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_blink_gen #(.HALF(BLINK_HALF)) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .wave  (blink_wave)
  );

  assign sample_w  = pin_sync ^ inv_q;
  assign rise_evt  = rise_of(sample_w, prev_q);
  assign clr_write = bus_we && (sel == RI_EPEND);
  assign keep_mask = clr_write ? bus_wdata : ALL_ONES;
  assign line_req  = (sample_w & len_q) | (epend_q & een_q);

  gpio_grp_or #(.NUM_LINES(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) u_grp (
    .line_req (line_req),
    .grp_req  (irq_grp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= ALL_ONES;
      blink_q <= '0;
      inv_q   <= '0;
      een_q   <= '0;
      len_q   <= '0;
    end else if (bus_we) begin
      case (sel)
        RI_OUT:   out_q   <= bus_wdata;
        RI_DIR:   dir_q   <= bus_wdata;
        RI_BLINK: blink_q <= bus_wdata;
        RI_INV:   inv_q   <= bus_wdata;
        RI_EEN:   een_q   <= bus_wdata;
        RI_LEN:   len_q   <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epend_q <= '0;
      prev_q  <= '0;
    end else begin
      epend_q <= pend_next(epend_q, keep_mask, rise_evt);
      prev_q  <= sample_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_re) begin
      case (sel)
        RI_OUT:    rdata_q <= out_q;
        RI_DIR:    rdata_q <= dir_q;
        RI_BLINK:  rdata_q <= blink_q;
        RI_INV:    rdata_q <= inv_q;
        RI_SAMPLE: rdata_q <= sample_w;
        RI_EPEND:  rdata_q <= epend_q;
        RI_EEN:    rdata_q <= een_q;
        default:   rdata_q <= len_q;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_oe    = ~dir_q;
  assign pad_out   = drive_of(out_q, blink_q, blink_wave);

  // R2: a direction write shows on the enables at the next cycle
  assert_oe_after_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == RI_DIR) |=> (pad_oe == ~$past(bus_wdata)));

  // R5: without a clearing write, no pending bit ever drops
  assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_write |=> ((epend_q & $past(epend_q)) == $past(epend_q)));

  // R7: every rising event is present in the pending register next cycle
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_evt) |=> ((epend_q & $past(rise_evt)) == $past(rise_evt)));

  // R6: bits written as zero with no coincident event are gone
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_write |=> ((epend_q & ~$past(bus_wdata) & ~$past(rise_evt)) == '0));

  // R8: with both enable masks clear no group may request
  assert_quiet_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (een_q == '0 && len_q == '0) |-> (irq_grp == '0));

endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int N  = 32;
  localparam int NG = N / 8;
  localparam int BH = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic [NG-1:0] irq_grp;

  int vectors = 0;
  int errors  = 0;
  bit cmp_on  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_unit #(.NUM_LINES(N), .GROUP_SIZE(8), .BLINK_HALF(BH), .ADDR_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_grp(irq_grp));

  // behavioural reference state
  bit [N-1:0] m_out, m_dir, m_blink, m_inv, m_pend, m_een, m_len;
  bit [N-1:0] m_p1, m_p2, m_last, m_rd;
  int m_cnt;
  bit m_wave;

  function automatic bit [N-1:0] m_read(int idx);
    case (idx)
      0: return m_out;
      1: return m_dir;
      2: return m_blink;
      3: return m_inv;
      4: return m_p2 ^ m_inv;
      5: return m_pend;
      6: return m_een;
      default: return m_len;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_dir = '1; m_blink = '0; m_inv = '0;
      m_pend = '0; m_een = '0; m_len = '0;
      m_p1 = '0; m_p2 = '0; m_last = '0; m_rd = '0;
      m_cnt = 0; m_wave = 1'b0;
    end else begin
      bit [N-1:0] now_v, keep_v;
      int idx;
      idx = int'(bus_addr) / 4;
      now_v = m_p2 ^ m_inv;
      keep_v = '1;
      if (bus_re) m_rd = m_read(idx);
      if (bus_we) begin
        case (idx)
          0: m_out = bus_wdata;
          1: m_dir = bus_wdata;
          2: m_blink = bus_wdata;
          3: m_inv = bus_wdata;
          5: keep_v = bus_wdata;
          6: m_een = bus_wdata;
          7: m_len = bus_wdata;
          default: ;
        endcase
      end
      for (int b = 0; b < N; b++) begin
        if (now_v[b] && !m_last[b]) m_pend[b] = 1'b1;
        else if (!keep_v[b]) m_pend[b] = 1'b0;
      end
      m_last = now_v;
      m_p2 = m_p1;
      m_p1 = pad_in;
      if (m_cnt == BH - 1) begin
        m_cnt = 0;
        m_wave = ~m_wave;
      end else begin
        m_cnt++;
      end
    end
  end

  function automatic bit [NG-1:0] exp_irq();
    bit [NG-1:0] r = '0;
    bit [N-1:0] now_v = m_p2 ^ m_inv;
    for (int b = 0; b < N; b++)
      if ((now_v[b] && m_len[b]) || (m_pend[b] && m_een[b])) r[b/8] = 1'b1;
    return r;
  endfunction

  function automatic bit [N-1:0] exp_out();
    bit [N-1:0] r;
    for (int b = 0; b < N; b++) r[b] = m_blink[b] ? m_wave : m_out[b];
    return r;
  endfunction

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      vectors += 4;
      if (pad_oe !== ~m_dir) begin
        errors++; $display("FAIL R2 pad_oe act=%h exp=%h", pad_oe, ~m_dir);
      end
      if (pad_out !== exp_out()) begin
        errors++; $display("FAIL R10 pad_out act=%h exp=%h", pad_out, exp_out());
      end
      if (irq_grp !== exp_irq()) begin
        errors++; $display("FAIL R8 irq_grp act=%h exp=%h", irq_grp, exp_irq());
      end
      if (bus_rdata !== m_rd) begin
        errors++; $display("FAIL R1 bus_rdata act=%h exp=%h", bus_rdata, m_rd);
      end
    end
  end

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [N-1:0] d);
    @(negedge clk);
    bus_addr = 5'(idx * 4); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int idx, output logic [N-1:0] d);
    @(negedge clk);
    bus_addr = 5'(idx * 4); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    int gap;
    idle(4);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 oe after reset", pad_oe, '0);
    chk("R9 irq after reset", N'(irq_grp), '0);
    rd(5, v); chk("R9 pending after reset", v, '0);
    rd(1, v); chk("R9 direction after reset", v, '1);
    rd(7, v); chk("R9 level enable after reset", v, '0);

    // R1 register map, R2 drive
    wr(0, 32'h1234_5678);
    wr(1, 32'hFFFF_0000);
    rd(0, v); chk("R1 output readback", v, 32'h1234_5678);
    rd(1, v); chk("R1 direction readback", v, 32'hFFFF_0000);
    chk("R2 enables", pad_oe, 32'h0000_FFFF);
    chk("R2 driven low half", N'(pad_out[15:0]), 32'h0000_5678);

    // R3 sampling with inversion
    wr(3, 32'h0000_FFFF);
    @(negedge clk); pad_in = 32'hA5A5_0000;
    idle(3);
    rd(4, v); chk("R3 sampled input", v, 32'hA5A5_FFFF);
    // R4 read-only
    wr(4, 32'h0000_0000);
    rd(4, v); chk("R4 sample after write", v, 32'hA5A5_FFFF);
    wr(5, 32'h0);
    rd(5, v); chk("R6 all-zero clear", v, '0);

    // R5 rising edge latches, survives falling edge
    @(negedge clk); pad_in[17] = 1'b1;
    idle(4);
    rd(5, v); chk("R5 rise latched", v, 32'h0002_0000);
    @(negedge clk); pad_in[17] = 1'b0;
    idle(4);
    rd(5, v); chk("R5 held after fall", v, 32'h0002_0000);

    // R6 partial clear keeps ones
    @(negedge clk); pad_in[19] = 1'b1;
    idle(4);
    wr(5, ~32'h0008_0000);
    rd(5, v); chk("R6 partial clear", v, 32'h0002_0000);

    // R8 grouping: bit 17 in group 2, bit 9 (inverted low pin) in group 1
    wr(6, 32'h0002_0000);
    chk("R8 edge source group", N'(irq_grp), 32'h4);
    wr(7, 32'h0000_0200);
    chk("R8 level source group", N'(irq_grp), 32'h6);
    wr(6, 32'h0); wr(7, 32'h0);
    chk("R8 all masked", N'(irq_grp), 32'h0);

    // R7 rising event coincides with all-zero clearing write
    wr(5, 32'h0);
    @(negedge clk); pad_in[22] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 5'd20; bus_wdata = '0; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(5, v); chk("R7 set beats clear", v, 32'h0040_0000);

    // R10 blink on line 0
    wr(1, 32'hFFFF_FFFE);
    wr(2, 32'h0000_0001);
    chk("R10 non-blink line keeps value", N'(pad_out[1]), 32'h0);
    v[0] = pad_out[0];
    for (int i = 0; i < 20 && pad_out[0] == v[0]; i++) @(negedge clk);
    v[0] = pad_out[0];
    gap = 0;
    for (int i = 0; i < 20 && pad_out[0] == v[0]; i++) begin
      @(negedge clk); gap++;
    end
    chk("R10 blink half period", 32'(gap), 32'(BH));

    // mixed traffic, reference compared every clock
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      bus_we = 1'b0; bus_re = 1'b0;
      if ($urandom % 3 == 0) pad_in[$urandom % N] ^= 1'b1;
      case ($urandom % 4)
        0: begin
          bus_addr = 5'(($urandom % 8) * 4);
          bus_wdata = (bus_addr == 5'd20) ? ~(32'h1 << ($urandom % N)) : 32'($urandom);
          bus_we = 1'b1;
        end
        1: begin
          bus_addr = 5'(($urandom % 8) * 4);
          bus_re = 1'b1;
        end
        default: ;
      endcase
    end
    @(negedge clk); bus_we = 1'b0; bus_re = 1'b0;
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule